// File: doc/BRIEF.md
# Bit-Addressable Space Decoder and Bit Unit

This block resolves an 8-bit absolute bit address into the byte that holds the bit and the bit's position inside that byte. The lower half of the bit space lands in a 16-byte window of internal RAM starting at byte 0x20. The upper half lands in the special function registers whose byte address is a multiple of eight. A select output tells the surrounding datapath which of the two stores to use.

In the same pass the block runs one single-bit operation against the byte read from that location and the incoming carry flag. It produces the byte to write back and its write enable, the new carry, and a branch-taken flag for the conditional jumps. The byte is written back with every other bit unchanged. All outputs are registered and appear one clock after the inputs are presented. Program-counter arithmetic belongs to the caller.

Top module: `bitu_top`

## Requirements
- R1: A bit address below 0x80 gives byte address 0x20 + (addr >> 3) with sfr_sel_o = 0.
- R2: A bit address of 0x80 or above gives byte address addr & 0xF8 with sfr_sel_o = 1.
- R3: The bit position is addr[2:0]. Set (op 0), clear (op 1) and complement (op 2) assert we_o and write the byte back with only that bit changed. The carry passes through unchanged.
- R4: Store-carry (op 3) writes the carry into the addressed bit and asserts we_o, leaving the carry unchanged.
- R5: Load-carry (op 4) sets the carry to the addressed bit and asserts no write.
- R6: Carry logic ops set the new carry without a write. AND uses op 5, and AND with the complemented bit uses op 6. OR uses op 7, and OR with the complement uses op 8. XOR uses op 9, and XOR with the complement uses op 10.
- R7: Jump-if-set (op 11) raises taken_o when the bit is 1. Jump-if-clear (op 12) raises it when the bit is 0. Neither op asserts we_o.
- R8: Jump-if-set-and-clear (op 13) raises taken_o when the bit is 1, and in that case also asserts we_o with the bit written as 0. When the bit is 0 it asserts neither.
- R9: Ops 14 and 15 have no effect: no write, no branch, and the carry passes through.
- R10: Every output is registered, so a result appears one clock after its inputs. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_addr_i | input | 8 | Absolute bit address |
| op_i | input | 4 | Bit operation code |
| rdata_i | input | 8 | Byte read from the mapped location |
| carry_i | input | 1 | Current carry flag |
| byte_addr_o | output | 8 | Mapped byte address |
| sfr_sel_o | output | 1 | 1 selects the SFR space, 0 selects internal RAM |
| wdata_o | output | 8 | Byte to write back |
| we_o | output | 1 | Write enable for wdata_o |
| carry_o | output | 1 | New carry flag |
| taken_o | output | 1 | Branch taken |

## Verification
A fault in the address map shows up as a wrong byte address or select on the very next clock after the address is applied, so every one of the 256 bit addresses is swept. A fault in the bit lanes shows up in wdata_o as a neighbouring bit flipped or kept, and it appears in the same cycle that we_o rises. Spurious writes are caught by the jump and carry-only ops. Wrong carry or branch decisions appear one clock after the op is presented. Byte patterns of all-zeros, all-ones, alternating bits and address-derived values, each with both carry values, make every bit value meet every op.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  localparam int BIT_ADDR_W = 8;
  localparam int DATA_W     = 8;
  localparam int OP_W       = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SETB    = 4'd0,
    OP_CLRB    = 4'd1,
    OP_CPLB    = 4'd2,
    OP_STC     = 4'd3,
    OP_LDC     = 4'd4,
    OP_ANDC    = 4'd5,
    OP_ANDNC   = 4'd6,
    OP_ORC     = 4'd7,
    OP_ORNC    = 4'd8,
    OP_XORC    = 4'd9,
    OP_XORNC   = 4'd10,
    OP_JSET    = 4'd11,
    OP_JCLR    = 4'd12,
    OP_JSETCLR = 4'd13,
    OP_RSV0    = 4'd14,
    OP_RSV1    = 4'd15
  } bit_op_e;
endpackage

// File: rtl/bitu_addr_map.sv
module bitu_addr_map #(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
  localparam int              POS_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              sfr_sel_o,
  output logic [POS_W-1:0]  bit_pos_o
);
  logic [ADDR_W-1:0] ram_byte, sfr_byte;

  assign sfr_sel_o = bit_addr_i[ADDR_W-1];
  assign bit_pos_o = bit_addr_i[POS_W-1:0];
  assign ram_byte  = RAM_BASE + {{(POS_W+1){1'b0}}, bit_addr_i[ADDR_W-2:POS_W]};
  assign sfr_byte  = {bit_addr_i[ADDR_W-1:POS_W], {POS_W{1'b0}}};
  assign byte_addr_o = sfr_sel_o ? sfr_byte : ram_byte;

  AST_SFR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_sel_o |-> (byte_addr_o[POS_W-1:0] == '0)); // R2
  AST_RAM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_sel_o |-> (byte_addr_o >= RAM_BASE && byte_addr_o < RAM_BASE + ADDR_W'(16))); // R1
endmodule

// File: rtl/bitu_core.sv
module bitu_core
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              carry_o,
  output logic              taken_o
);
  bit_op_e op;
  logic    bit_val, new_bit;

  assign op      = bit_op_e'(op_i);
  assign bit_val = rdata_i[bit_pos_i];

  always_comb begin
    new_bit = bit_val;
    we_o    = 1'b0;
    carry_o = carry_i;
    taken_o = 1'b0;
    unique case (op)
      OP_SETB:    begin new_bit = 1'b1;     we_o = 1'b1; end
      OP_CLRB:    begin new_bit = 1'b0;     we_o = 1'b1; end
      OP_CPLB:    begin new_bit = ~bit_val; we_o = 1'b1; end
      OP_STC:     begin new_bit = carry_i;  we_o = 1'b1; end
      OP_LDC:     carry_o = bit_val;
      OP_ANDC:    carry_o = carry_i & bit_val;
      OP_ANDNC:   carry_o = carry_i & ~bit_val;
      OP_ORC:     carry_o = carry_i | bit_val;
      OP_ORNC:    carry_o = carry_i | ~bit_val;
      OP_XORC:    carry_o = carry_i ^ bit_val;
      OP_XORNC:   carry_o = carry_i ^ ~bit_val;
      OP_JSET:    taken_o = bit_val;
      OP_JCLR:    taken_o = ~bit_val;
      OP_JSETCLR: begin taken_o = bit_val; we_o = bit_val; new_bit = 1'b0; end
      default:    ;
    endcase
  end

  // One write lane per bit: only the addressed lane takes the new value
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign wdata_o[i] = (bit_pos_i == POS_W'(i)) ? new_bit : rdata_i[i];
  end

  AST_SINGLE_BIT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ($countones(wdata_o ^ rdata_i) <= 1)); // R3
  AST_JUMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_JSET || op_i == OP_JCLR) |-> !we_o); // R7
  AST_JSETCLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_JSETCLR && we_o) |-> (taken_o && wdata_o[bit_pos_i] == 1'b0)); // R8
  AST_CARRY_OP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= OP_LDC && op_i <= OP_XORNC) |-> (!we_o && !taken_o)); // R6
  AST_RSV_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= OP_RSV0) |-> (!we_o && !taken_o && carry_o == carry_i)); // R9
endmodule

// File: rtl/bitu_top.sv
module bitu_top
  import bitu_pkg::*;
#(
  parameter int ADDR_W = BIT_ADDR_W,
  parameter int D_W    = DATA_W,
  localparam int POS_W = $clog2(D_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [D_W-1:0]    rdata_i,
  input  logic              carry_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              sfr_sel_o,
  output logic [D_W-1:0]    wdata_o,
  output logic              we_o,
  output logic              carry_o,
  output logic              taken_o
);
  logic [ADDR_W-1:0] byte_addr_c;
  logic              sfr_sel_c, we_c, carry_c, taken_c;
  logic [POS_W-1:0]  bit_pos_c;
  logic [D_W-1:0]    wdata_c;

  bitu_addr_map #(.ADDR_W(ADDR_W), .DATA_W(D_W)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_addr_i (bit_addr_i),
    .byte_addr_o(byte_addr_c),
    .sfr_sel_o  (sfr_sel_c),
    .bit_pos_o  (bit_pos_c)
  );

  bitu_core #(.DATA_W(D_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .bit_pos_i(bit_pos_c),
    .rdata_i  (rdata_i),
    .carry_i  (carry_i),
    .wdata_o  (wdata_c),
    .we_o     (we_c),
    .carry_o  (carry_c),
    .taken_o  (taken_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_addr_o <= '0;
      sfr_sel_o   <= 1'b0;
      wdata_o     <= '0;
      we_o        <= 1'b0;
      carry_o     <= 1'b0;
      taken_o     <= 1'b0;
    end else begin
      byte_addr_o <= byte_addr_c;
      sfr_sel_o   <= sfr_sel_c;
      wdata_o     <= wdata_c;
      we_o        <= we_c;
      carry_o     <= carry_c;
      taken_o     <= taken_c;
    end
  end

  AST_WE_TAKEN_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_c |=> we_o); // R10
endmodule

// File: tb/bitu_top_test.sv
`timescale 1ns/1ps
module bitu_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bit_addr = '0;
  logic [3:0] op = '0;
  logic [7:0] rdata = '0;
  logic       carry = 1'b0;
  logic [7:0] byte_addr, wdata;
  logic       sfr_sel, we, carry_o, taken;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitu_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_addr_i(bit_addr), .op_i(op),
    .rdata_i(rdata), .carry_i(carry), .byte_addr_o(byte_addr),
    .sfr_sel_o(sfr_sel), .wdata_o(wdata), .we_o(we),
    .carry_o(carry_o), .taken_o(taken)
  );

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3:             return "R4";
      4'd4:             return "R5";
      4'd11, 4'd12:     return "R7";
      4'd13:            return "R8";
      4'd14, 4'd15:     return "R9";
      default:          return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h op %0d rd %0h c %0b)",
               tag, act, exp, bit_addr, op, rdata, carry);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [3:0] o, input logic [7:0] rd, input logic c);
    logic [2:0] pos;
    logic       b, e_we, e_c, e_tk, nb;
    logic [7:0] e_addr, e_wd;
    bit_addr = a; op = o; rdata = rd; carry = c;
    pos = a[2:0];
    b = rd[pos];
    e_addr = a[7] ? (a & 8'hF8) : (8'h20 + {3'b0, a[7:3]});
    e_we = 0; e_c = c; e_tk = 0; nb = b;
    case (o)
      4'd0:  begin e_we = 1; nb = 1; end
      4'd1:  begin e_we = 1; nb = 0; end
      4'd2:  begin e_we = 1; nb = ~b; end
      4'd3:  begin e_we = 1; nb = c; end
      4'd4:  e_c = b;
      4'd5:  e_c = c & b;
      4'd6:  e_c = c & ~b;
      4'd7:  e_c = c | b;
      4'd8:  e_c = c | ~b;
      4'd9:  e_c = c ^ b;
      4'd10: e_c = ~(c ^ b);
      4'd11: e_tk = b;
      4'd12: e_tk = ~b;
      4'd13: begin e_tk = b; e_we = b; nb = 0; end
      default: ;
    endcase
    e_wd = nb ? (rd | (8'd1 << pos)) : (rd & ~(8'd1 << pos));
    @(posedge clk); #1;
    // one register stage: result visible after a single edge (R10)
    check(a[7] ? "R2" : "R1", {23'd0, sfr_sel, byte_addr}, {23'd0, a[7], e_addr});
    check(op_tag(o), {29'd0, we, carry_o, taken}, {29'd0, e_we, e_c, e_tk});
    if (e_we) check(op_tag(o), {24'd0, wdata}, {24'd0, e_wd});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", {20'd0, byte_addr, wdata, sfr_sel, we, carry_o, taken}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) begin
      for (int o = 0; o < 16; o++) begin
        for (int p = 0; p < 4; p++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] rd;
            case (p)
              0: rd = 8'h00;
              1: rd = 8'hFF;
              2: rd = (a[0] ? 8'h5A : 8'hA5);
              default: rd = 8'(a * 37 + o);
            endcase
            apply(8'(a), 4'(o), rd, c[0]);
          end
        end
      end
    end
    // back-to-back latency: a changed input must replace the result after one edge (R10)
    apply(8'h85, 4'd0, 8'h00, 1'b0);
    check("R10", {24'd0, wdata}, 32'h20);
    apply(8'h07, 4'd13, 8'h80, 1'b1);
    check("R10", {30'd0, we, taken}, 32'h3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule